// File: doc/BRIEF.md
# Pipelined 2-3 Tree Lookup Engine

This block searches a balanced 2-3 tree that is spread across a linear pipeline, with one stage for each tree level. Each stage owns a private node memory. A lookup enters with a 32-bit key. At every active stage it reads one node at the address carried with it and compares the key against the node's one or two keys. The command then either records a hit or carries the chosen child address down to the next stage. A new lookup can be accepted on every clock, and results leave the last stage in issue order.

The tree may be shorter than the pipeline. A root register names the stage that holds the root node and the local address of that node. Stages above the root pass commands through without reading memory. A command that has already hit stops reading memory and keeps the location of its hit. A command that reaches the null child address becomes a miss. An invalidate request can mark a command in flight. That command finishes without further processing and leaves flagged as invalid. The node memories and the root register are loaded through simple write ports, and no tree maintenance takes place inside the block.

Top module: `t23_lookup_pipe`

## Requirements
- R1: A write with `mem_we` high stores `mem_node` at `mem_addr` in the memory of stage `mem_stage`. Node layout: bit 0 is the full flag (1 = two keys, 0 = one key), bits [ADDR_W:1] are the left child, the next ADDR_W bits are the middle child, the next ADDR_W bits are the right child, then come KEY_W bits of the first key and KEY_W bits of the second key at the top.
- R2: In a one-key node, a key below the first key descends left, an equal key is a hit on the first key, and a larger key descends middle.
- R3: In a two-key node, a key below the first key descends left, equal to the first key is a hit on the first key, a key between the two keys descends middle, equal to the second key is a hit on the second key, and a key above the second key descends right.
- R4: Keys are compared as unsigned numbers.
- R5: A result reports `out_found`, reports `out_hit_b` high only for a hit on the second key, and reports the stage index and local node address of the hit, together with the key that was looked up.
- R6: A command that has hit makes no further memory reads. Its reported hit location stays the stage where it first hit, even when deeper nodes on its address path hold the same key.
- R7: Stages with an index below `root_stage` pass commands through unchanged. The search starts at `root_stage` with node address `root_addr`, both loaded by `cfg_root_we`. After reset both are zero.
- R8: Node address 0 is null. A command whose current address is 0 reads no memory and ends as a miss, and a hit is never reported at address 0.
- R9: One lookup can be accepted every cycle. Each result appears exactly 2*LEVELS cycles after its command, in issue order, and `out_valid`, `out_found`, `out_hit_b` and `out_invalid` are low on idle cycles.
- R10: When `inv_en` is high, the command entering stage `inv_stage` in that cycle is marked invalid. It leaves with `out_invalid` high and `out_found` low.
- R11: During and after reset, with no lookups issued, `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_root_we | input | 1 | Load the root register |
| cfg_root_stage | input | STG_W | Stage holding the root node |
| cfg_root_addr | input | ADDR_W | Local address of the root node |
| mem_we | input | 1 | Node memory write strobe |
| mem_stage | input | STG_W | Stage whose memory is written |
| mem_addr | input | ADDR_W | Node address to write |
| mem_node | input | NODE_W | Node word to write |
| inv_en | input | 1 | Invalidate the command entering `inv_stage` |
| inv_stage | input | STG_W | Stage targeted by invalidate |
| in_valid | input | 1 | New lookup command |
| in_key | input | KEY_W | Key to search for |
| out_valid | output | 1 | Result valid |
| out_found | output | 1 | Key was found |
| out_hit_b | output | 1 | Hit was on the second key of a node |
| out_invalid | output | 1 | Command was invalidated in flight |
| out_stage | output | STG_W | Stage of the hit |
| out_addr | output | ADDR_W | Node address of the hit |
| out_key | output | KEY_W | Key that was looked up |

## Verification
A three-level tree is loaded below an idle top stage. Single lookups then hit each key position in one-key and two-key nodes at every level, and misses fall off each kind of child edge, so every branch of the comparison is told apart by its reported location. A back-to-back burst separates one-per-cycle acceptance and fixed latency from a design that stalls or reorders. Moving the root to deeper stages, or to the null address, separates correct pass-through from stray reads, and a planted duplicate key below an early hit shows whether reads stop after a match. A large key above the top bit exposes a signed comparison, and invalidation at the first, middle and last stage checks that marking is kept from the point of invalidation to the output.

// File: rtl/t23_pkg.sv
package t23_pkg;

   // Outcome of comparing a search key against one tree node
   typedef enum logic [2:0] {
      STEP_LEFT  = 3'd0,
      STEP_MID   = 3'd1,
      STEP_RIGHT = 3'd2,
      STEP_HIT_A = 3'd3,
      STEP_HIT_B = 3'd4
   } step_e;

endpackage

// File: rtl/t23_node_mem.sv
module t23_node_mem #(
   parameter int ADDR_W = 4,
   parameter int NODE_W = 77
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [NODE_W-1:0] wr_node,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [NODE_W-1:0] rd_node
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [NODE_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_node;
   end

   // one-cycle registered read
   always_ff @(posedge clk) begin
      if (rd_en) rd_node <= mem[rd_addr];
   end

endmodule

// File: rtl/t23_node_cmp.sv
module t23_node_cmp
   import t23_pkg::*;
#(
   parameter int KEY_W  = 32,
   parameter int ADDR_W = 4
) (
   input  logic [KEY_W-1:0]              key,
   input  logic [2*KEY_W+3*ADDR_W:0]     node,
   output step_e                         step,
   output logic [ADDR_W-1:0]             child
);

   localparam int OFS_L  = 1;
   localparam int OFS_M  = OFS_L + ADDR_W;
   localparam int OFS_R  = OFS_M + ADDR_W;
   localparam int OFS_KA = OFS_R + ADDR_W;
   localparam int OFS_KB = OFS_KA + KEY_W;

   logic              full;
   logic [ADDR_W-1:0] c_l, c_m, c_r;
   logic [KEY_W-1:0]  ka, kb;

   assign full = node[0];
   assign c_l  = node[OFS_L  +: ADDR_W];
   assign c_m  = node[OFS_M  +: ADDR_W];
   assign c_r  = node[OFS_R  +: ADDR_W];
   assign ka   = node[OFS_KA +: KEY_W];
   assign kb   = node[OFS_KB +: KEY_W];

   // unsigned ordering: logic vectors compare without sign
   always_comb begin
      step  = STEP_LEFT;
      child = c_l;
      if (key < ka) begin
         step  = STEP_LEFT;
         child = c_l;
      end else if (key == ka) begin
         step  = STEP_HIT_A;
         child = '0;
      end else if (!full || key < kb) begin
         step  = STEP_MID;
         child = c_m;
      end else if (key == kb) begin
         step  = STEP_HIT_B;
         child = '0;
      end else begin
         step  = STEP_RIGHT;
         child = c_r;
      end
   end

endmodule

// File: rtl/t23_stage.sv
module t23_stage
   import t23_pkg::*;
#(
   parameter int KEY_W     = 32,
   parameter int ADDR_W    = 4,
   parameter int STG_W     = 2,
   parameter int STAGE_IDX = 0
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      active,
   input  logic                      kill,
   input  logic                      wr_en,
   input  logic [ADDR_W-1:0]         wr_addr,
   input  logic [2*KEY_W+3*ADDR_W:0] wr_node,
   input  logic                      i_valid,
   input  logic                      i_inv,
   input  logic                      i_hit_a,
   input  logic                      i_hit_b,
   input  logic [KEY_W-1:0]          i_key,
   input  logic [ADDR_W-1:0]         i_addr,
   input  logic [STG_W-1:0]          i_hstage,
   input  logic [ADDR_W-1:0]         i_haddr,
   output logic                      o_valid,
   output logic                      o_inv,
   output logic                      o_hit_a,
   output logic                      o_hit_b,
   output logic [KEY_W-1:0]          o_key,
   output logic [ADDR_W-1:0]         o_addr,
   output logic [STG_W-1:0]          o_hstage,
   output logic [ADDR_W-1:0]         o_haddr,
   output logic                      rd_en,
   output logic [ADDR_W-1:0]         rd_addr
);

   localparam int NODE_W = 2*KEY_W + 3*ADDR_W + 1;

   logic              inv_now;
   logic [NODE_W-1:0] rd_node;
   step_e             step;
   logic [ADDR_W-1:0] child;

   // first half: read issue
   logic              p1_valid, p1_inv, p1_hit_a, p1_hit_b, p1_look;
   logic [KEY_W-1:0]  p1_key;
   logic [ADDR_W-1:0] p1_addr, p1_haddr;
   logic [STG_W-1:0]  p1_hstage;

   // decision computed from read data
   logic              n_hit_a, n_hit_b;
   logic [ADDR_W-1:0] n_addr, n_haddr;
   logic [STG_W-1:0]  n_hstage;

   assign inv_now = i_inv | kill;
   assign rd_en   = i_valid & active & ~inv_now & ~i_hit_a & ~i_hit_b
                    & (i_addr != '0);
   assign rd_addr = i_addr;

   t23_node_mem #(.ADDR_W(ADDR_W), .NODE_W(NODE_W)) u_mem (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_node (wr_node),
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .rd_node (rd_node)
   );

   t23_node_cmp #(.KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_cmp (
      .key   (p1_key),
      .node  (rd_node),
      .step  (step),
      .child (child)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         p1_valid <= 1'b0;
         p1_inv   <= 1'b0;
         p1_hit_a <= 1'b0;
         p1_hit_b <= 1'b0;
         p1_look  <= 1'b0;
      end else begin
         p1_valid <= i_valid;
         p1_inv   <= i_valid & inv_now;
         p1_hit_a <= i_valid & i_hit_a;
         p1_hit_b <= i_valid & i_hit_b;
         p1_look  <= rd_en;
      end
   end

   always_ff @(posedge clk) begin
      p1_key    <= i_key;
      p1_addr   <= i_addr;
      p1_hstage <= i_hstage;
      p1_haddr  <= i_haddr;
   end

   always_comb begin
      n_hit_a  = p1_hit_a;
      n_hit_b  = p1_hit_b;
      n_addr   = p1_addr;
      n_hstage = p1_hstage;
      n_haddr  = p1_haddr;
      if (p1_look) begin
         unique case (step)
            STEP_HIT_A, STEP_HIT_B: begin
               n_hit_a  = (step == STEP_HIT_A);
               n_hit_b  = (step == STEP_HIT_B);
               n_hstage = STG_W'(STAGE_IDX);
               n_haddr  = p1_addr;
            end
            default: n_addr = child;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         o_valid <= 1'b0;
         o_inv   <= 1'b0;
         o_hit_a <= 1'b0;
         o_hit_b <= 1'b0;
      end else begin
         o_valid <= p1_valid;
         o_inv   <= p1_inv;
         o_hit_a <= p1_valid & n_hit_a;
         o_hit_b <= p1_valid & n_hit_b;
      end
   end

   always_ff @(posedge clk) begin
      o_key    <= p1_key;
      o_addr   <= n_addr;
      o_hstage <= n_hstage;
      o_haddr  <= n_haddr;
   end

endmodule

// File: rtl/t23_lookup_pipe.sv
module t23_lookup_pipe #(
   parameter int LEVELS = 4,
   parameter int KEY_W  = 32,
   parameter int ADDR_W = 4,
   localparam int STG_W  = (LEVELS > 1) ? $clog2(LEVELS) : 1,
   localparam int NODE_W = 2*KEY_W + 3*ADDR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_root_we,
   input  logic [STG_W-1:0]  cfg_root_stage,
   input  logic [ADDR_W-1:0] cfg_root_addr,
   input  logic              mem_we,
   input  logic [STG_W-1:0]  mem_stage,
   input  logic [ADDR_W-1:0] mem_addr,
   input  logic [NODE_W-1:0] mem_node,
   input  logic              inv_en,
   input  logic [STG_W-1:0]  inv_stage,
   input  logic              in_valid,
   input  logic [KEY_W-1:0]  in_key,
   output logic              out_valid,
   output logic              out_found,
   output logic              out_hit_b,
   output logic              out_invalid,
   output logic [STG_W-1:0]  out_stage,
   output logic [ADDR_W-1:0] out_addr,
   output logic [KEY_W-1:0]  out_key
);

   generate
      if (LEVELS < 1 || LEVELS > 32) begin : g_bad_levels
         $error("LEVELS must lie in 1..32");
      end
      if (KEY_W < 2 || KEY_W > 64) begin : g_bad_key
         $error("KEY_W must lie in 2..64");
      end
      if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
         $error("ADDR_W must lie in 1..12");
      end
   endgenerate

   logic [STG_W-1:0]  root_stage_q;
   logic [ADDR_W-1:0] root_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         root_stage_q <= '0;
         root_addr_q  <= '0;
      end else if (cfg_root_we) begin
         root_stage_q <= cfg_root_stage;
         root_addr_q  <= cfg_root_addr;
      end
   end

   // chain between stages: index 0 is the entry, LEVELS the exit
   logic              c_valid [LEVELS+1];
   logic              c_inv   [LEVELS+1];
   logic              c_hit_a [LEVELS+1];
   logic              c_hit_b [LEVELS+1];
   logic [KEY_W-1:0]  c_key   [LEVELS+1];
   logic [ADDR_W-1:0] c_addr  [LEVELS+1];
   logic [STG_W-1:0]  c_hstg  [LEVELS+1];
   logic [ADDR_W-1:0] c_haddr [LEVELS+1];

   logic [LEVELS-1:0]        stage_rd;
   logic [LEVELS*ADDR_W-1:0] stage_rd_addr;

   assign c_valid[0] = in_valid;
   assign c_inv[0]   = 1'b0;
   assign c_hit_a[0] = 1'b0;
   assign c_hit_b[0] = 1'b0;
   assign c_key[0]   = in_key;
   assign c_addr[0]  = root_addr_q;
   assign c_hstg[0]  = '0;
   assign c_haddr[0] = '0;

   for (genvar s = 0; s < LEVELS; s++) begin : g_stage
      logic              active_s, kill_s, wr_s;
      logic [ADDR_W-1:0] rd_addr_s;

      assign active_s = (STG_W'(s) >= root_stage_q);
      assign kill_s   = inv_en && (inv_stage == STG_W'(s));
      assign wr_s     = mem_we && (mem_stage == STG_W'(s));
      assign stage_rd_addr[s*ADDR_W +: ADDR_W] = rd_addr_s;

      t23_stage #(
         .KEY_W(KEY_W), .ADDR_W(ADDR_W), .STG_W(STG_W), .STAGE_IDX(s)
      ) u_stage (
         .clk      (clk),
         .rst_n    (rst_n),
         .active   (active_s),
         .kill     (kill_s),
         .wr_en    (wr_s),
         .wr_addr  (mem_addr),
         .wr_node  (mem_node),
         .i_valid  (c_valid[s]),
         .i_inv    (c_inv[s]),
         .i_hit_a  (c_hit_a[s]),
         .i_hit_b  (c_hit_b[s]),
         .i_key    (c_key[s]),
         .i_addr   (c_addr[s]),
         .i_hstage (c_hstg[s]),
         .i_haddr  (c_haddr[s]),
         .o_valid  (c_valid[s+1]),
         .o_inv    (c_inv[s+1]),
         .o_hit_a  (c_hit_a[s+1]),
         .o_hit_b  (c_hit_b[s+1]),
         .o_key    (c_key[s+1]),
         .o_addr   (c_addr[s+1]),
         .o_hstage (c_hstg[s+1]),
         .o_haddr  (c_haddr[s+1]),
         .rd_en    (stage_rd[s]),
         .rd_addr  (rd_addr_s)
      );
   end

   logic exit_hit;
   logic unused_exit_addr;

   assign exit_hit    = (c_hit_a[LEVELS] | c_hit_b[LEVELS]) & ~c_inv[LEVELS];
   assign out_valid   = c_valid[LEVELS];
   assign out_found   = exit_hit;
   assign out_hit_b   = c_hit_b[LEVELS] & ~c_inv[LEVELS];
   assign out_invalid = c_inv[LEVELS];
   assign out_stage   = c_hstg[LEVELS];
   assign out_addr    = c_haddr[LEVELS];
   assign out_key     = c_key[LEVELS];
   assign unused_exit_addr = ^c_addr[LEVELS];

endmodule

// File: rtl/t23_lookup_chk.sv
module t23_lookup_chk #(
   parameter int LEVELS = 4,
   parameter int ADDR_W = 4,
   parameter int STG_W  = 2
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic [STG_W-1:0]         root_stage_q,
   input logic [LEVELS-1:0]        stage_rd,
   input logic [LEVELS*ADDR_W-1:0] stage_rd_addr,
   input logic                     out_valid,
   input logic                     out_found,
   input logic                     out_hit_b,
   input logic                     out_invalid,
   input logic [ADDR_W-1:0]        out_addr
);

   // a hit is never reported at the null node
   assert_hit_not_null_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_found |-> out_addr != '0);

   // second-key flag only accompanies a hit
   assert_hit_b_found_R5: assert property (@(posedge clk) disable iff (!rst_n)
      out_hit_b |-> out_found);

   // idle cycles show no result flags
   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> !out_found && !out_invalid && !out_hit_b);

   // an invalidated command never reports a hit
   assert_inv_no_hit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      out_invalid |-> !out_found);

   for (genvar s = 0; s < LEVELS; s++) begin : g_chk
      // reads only from non-null addresses
      assert_rd_not_null_R8: assert property (@(posedge clk) disable iff (!rst_n)
         stage_rd[s] |-> stage_rd_addr[s*ADDR_W +: ADDR_W] != '0);
      // stages above the root never touch memory
      assert_rd_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
         stage_rd[s] |-> int'(root_stage_q) <= s);
   end

endmodule

bind t23_lookup_pipe t23_lookup_chk #(
   .LEVELS(LEVELS), .ADDR_W(ADDR_W), .STG_W(STG_W)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .root_stage_q  (root_stage_q),
   .stage_rd      (stage_rd),
   .stage_rd_addr (stage_rd_addr),
   .out_valid     (out_valid),
   .out_found     (out_found),
   .out_hit_b     (out_hit_b),
   .out_invalid   (out_invalid),
   .out_addr      (out_addr)
);

// File: tb/t23_lookup_pipe_tb.sv
module t23_lookup_pipe_tb;

   localparam int LEVELS = 4;
   localparam int KEY_W  = 32;
   localparam int ADDR_W = 4;
   localparam int STG_W  = 2;
   localparam int NODE_W = 2*KEY_W + 3*ADDR_W + 1;
   localparam int LAT    = 2*LEVELS;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_root_we = 1'b0;
   logic [STG_W-1:0]  cfg_root_stage = '0;
   logic [ADDR_W-1:0] cfg_root_addr = '0;
   logic              mem_we = 1'b0;
   logic [STG_W-1:0]  mem_stage = '0;
   logic [ADDR_W-1:0] mem_addr = '0;
   logic [NODE_W-1:0] mem_node = '0;
   logic              inv_en = 1'b0;
   logic [STG_W-1:0]  inv_stage = '0;
   logic              in_valid = 1'b0;
   logic [KEY_W-1:0]  in_key = '0;
   logic              out_valid, out_found, out_hit_b, out_invalid;
   logic [STG_W-1:0]  out_stage;
   logic [ADDR_W-1:0] out_addr;
   logic [KEY_W-1:0]  out_key;

   always #5 clk = ~clk;

   t23_lookup_pipe #(.LEVELS(LEVELS), .KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cfg_root_we(cfg_root_we), .cfg_root_stage(cfg_root_stage),
      .cfg_root_addr(cfg_root_addr),
      .mem_we(mem_we), .mem_stage(mem_stage), .mem_addr(mem_addr),
      .mem_node(mem_node),
      .inv_en(inv_en), .inv_stage(inv_stage),
      .in_valid(in_valid), .in_key(in_key),
      .out_valid(out_valid), .out_found(out_found), .out_hit_b(out_hit_b),
      .out_invalid(out_invalid), .out_stage(out_stage), .out_addr(out_addr),
      .out_key(out_key)
   );

   int n_chk = 0;
   int n_bad = 0;
   int cyc = 0;
   bit done = 1'b0;

   // expected results, filled at issue time
   logic [KEY_W-1:0]  e_key   [256];
   logic              e_found [256];
   logic              e_b     [256];
   logic              e_inv   [256];
   logic [STG_W-1:0]  e_stage [256];
   logic [ADDR_W-1:0] e_addr  [256];
   int                e_cyc   [256];
   string             e_req   [256];
   int wr_idx = 0;
   int rd_idx = 0;

   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [NODE_W-1:0] mk(input logic full,
         input logic [KEY_W-1:0] ka, input logic [KEY_W-1:0] kb,
         input logic [ADDR_W-1:0] l, input logic [ADDR_W-1:0] m,
         input logic [ADDR_W-1:0] r);
      return {kb, ka, r, m, l, full};
   endfunction

   // result monitor: compares each output against the oldest expectation
   always @(negedge clk) begin
      if (out_valid && !done) begin
         n_chk++;
         if (rd_idx >= wr_idx) begin
            n_bad++;
            $display("FAIL R9: unexpected output key=%0h (expected none)", out_key);
         end else begin
            int i;
            bit ok;
            i = rd_idx % 256;
            if (e_inv[i])
               ok = out_invalid && !out_found && out_key == e_key[i];
            else
               ok = !out_invalid && out_found == e_found[i] && out_hit_b == e_b[i]
                    && out_key == e_key[i]
                    && (!e_found[i] || (out_stage == e_stage[i] && out_addr == e_addr[i]));
            if (!ok) begin
               n_bad++;
               $display("FAIL %s: key=%0h got found=%0b b=%0b inv=%0b stg=%0d adr=%0d exp found=%0b b=%0b inv=%0b stg=%0d adr=%0d",
                  e_req[i], out_key, out_found, out_hit_b, out_invalid, out_stage, out_addr,
                  e_found[i], e_b[i], e_inv[i], e_stage[i], e_addr[i]);
            end
            n_chk++;
            if (cyc - e_cyc[i] != LAT) begin
               n_bad++;
               $display("FAIL R9: latency got %0d expected %0d", cyc - e_cyc[i], LAT);
            end
            rd_idx++;
         end
      end
   end

   task automatic wr_node(input int stg, input int adr, input logic [NODE_W-1:0] nd);
      mem_we = 1'b1; mem_stage = STG_W'(stg); mem_addr = ADDR_W'(adr); mem_node = nd;
      @(negedge clk);
      mem_we = 1'b0;
   endtask

   task automatic set_root(input int stg, input int adr);
      cfg_root_we = 1'b1; cfg_root_stage = STG_W'(stg); cfg_root_addr = ADDR_W'(adr);
      @(negedge clk);
      cfg_root_we = 1'b0;
   endtask

   task automatic record(input logic [KEY_W-1:0] k, input logic f, input logic b,
         input logic iv, input int stg, input int adr, input string req);
      int i;
      i = wr_idx % 256;
      e_key[i] = k; e_found[i] = f; e_b[i] = b; e_inv[i] = iv;
      e_stage[i] = STG_W'(stg); e_addr[i] = ADDR_W'(adr);
      e_cyc[i] = cyc; e_req[i] = req;
      wr_idx++;
   endtask

   // one lookup issued for one cycle; callers may chain calls back to back
   task automatic look(input logic [KEY_W-1:0] k, input logic f, input logic b,
         input int stg, input int adr, input string req);
      record(k, f, b, 1'b0, stg, adr, req);
      in_valid = 1'b1; in_key = k;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain(input string req);
      repeat (LAT + 2) @(negedge clk);
      n_chk++;
      if (rd_idx != wr_idx) begin
         n_bad++;
         $display("FAIL %s: outputs seen %0d expected %0d", req, rd_idx, wr_idx);
      end
   endtask

   task automatic load_tree();
      wr_node(1, 1, mk(1'b1, 40, 80, 1, 2, 3));
      wr_node(2, 1, mk(1'b0, 20, 0, 1, 2, 0));
      wr_node(2, 2, mk(1'b1, 50, 60, 3, 4, 5));
      wr_node(2, 3, mk(1'b0, 90, 0, 6, 7, 0));
      wr_node(3, 1, mk(1'b1, 5, 10, 0, 0, 0));
      wr_node(3, 2, mk(1'b0, 30, 0, 0, 0, 0));
      wr_node(3, 3, mk(1'b0, 45, 0, 0, 0, 0));
      wr_node(3, 4, mk(1'b1, 55, 58, 0, 0, 0));
      wr_node(3, 5, mk(1'b0, 70, 0, 0, 0, 0));
      wr_node(3, 6, mk(1'b0, 85, 0, 0, 0, 0));
      wr_node(3, 7, mk(1'b1, 95, 32'hF000_0000, 0, 0, 0));
   endtask

   task automatic t_reset();
      n_chk++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R11: out_valid=%b expected 0", out_valid);
      end
   endtask

   task automatic t_single();
      look(40, 1, 0, 1, 1, "R3");
      look(80, 1, 1, 1, 1, "R3");
      look(20, 1, 0, 2, 1, "R2");
      look(60, 1, 1, 2, 2, "R3");
      look(30, 1, 0, 3, 2, "R2");
      look(10, 1, 1, 3, 1, "R3");
      look(5,  1, 0, 3, 1, "R5");
      look(55, 1, 0, 3, 4, "R5");
      look(58, 1, 1, 3, 4, "R5");
      look(70, 1, 0, 3, 5, "R3");
      look(85, 1, 0, 3, 6, "R2");
      look(0,   0, 0, 0, 0, "R8");
      look(47,  0, 0, 0, 0, "R2");
      look(56,  0, 0, 0, 0, "R3");
      look(100, 0, 0, 0, 0, "R3");
      drain("R1");
   endtask

   task automatic t_unsigned();
      look(32'hF000_0000, 1, 1, 3, 7, "R4");
      look(32'h8000_0000, 0, 0, 0, 0, "R4");
      look(32'hFFFF_FFFF, 0, 0, 0, 0, "R4");
      drain("R4");
   endtask

   task automatic t_burst();
      look(40, 1, 0, 1, 1, "R9");
      look(20, 1, 0, 2, 1, "R9");
      look(56, 0, 0, 0, 0, "R9");
      look(95, 1, 0, 3, 7, "R9");
      look(32'hF000_0000, 1, 1, 3, 7, "R9");
      look(47, 0, 0, 0, 0, "R9");
      look(85, 1, 0, 3, 6, "R9");
      look(10, 1, 1, 3, 1, "R9");
      drain("R9");
   endtask

   task automatic t_root_move();
      set_root(3, 7);
      look(95, 1, 0, 3, 7, "R7");
      look(40, 0, 0, 0, 0, "R7");
      look(32'hF000_0000, 1, 1, 3, 7, "R7");
      drain("R7");
      set_root(2, 2);
      look(50, 1, 0, 2, 2, "R7");
      look(58, 1, 1, 3, 4, "R7");
      look(40, 0, 0, 0, 0, "R7");
      drain("R7");
      set_root(1, 0);
      look(40, 0, 0, 0, 0, "R8");
      look(80, 0, 0, 0, 0, "R8");
      drain("R8");
      set_root(1, 1);
   endtask

   task automatic t_skip_after_hit();
      // plant a duplicate of key 40 where a continued walk would read it
      wr_node(2, 1, mk(1'b0, 40, 0, 1, 2, 0));
      look(40, 1, 0, 1, 1, "R6");
      drain("R6");
      wr_node(2, 1, mk(1'b0, 20, 0, 1, 2, 0));
      look(20, 1, 0, 2, 1, "R1");
      drain("R1");
   endtask

   task automatic look_kill(input logic [KEY_W-1:0] k, input int stg);
      record(k, 0, 0, 1'b1, 0, 0, "R10");
      in_valid = 1'b1; in_key = k;
      if (stg == 0) begin
         inv_en = 1'b1; inv_stage = '0;
      end
      @(negedge clk);
      in_valid = 1'b0;
      inv_en = 1'b0;
      if (stg > 0) begin
         repeat (2*stg - 1) @(negedge clk);
         inv_en = 1'b1; inv_stage = STG_W'(stg);
         @(negedge clk);
         inv_en = 1'b0;
      end
   endtask

   task automatic t_invalidate();
      look_kill(58, 0);
      drain("R10");
      look_kill(40, 2);
      drain("R10");
      look_kill(58, 3);
      drain("R10");
      look(58, 1, 1, 3, 4, "R10");
      drain("R10");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      load_tree();
      set_root(1, 1);
      t_single();
      t_unsigned();
      t_burst();
      t_root_move();
      t_skip_after_hit();
      t_invalidate();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL R9: watchdog expired (got hang, expected completion)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule